// File: doc/BRIEF.md
# Coprocessor Control and Interrupt Register Bank

This block is a small bank of 16-bit registers that sits between a host core and a command-list execution unit. The host reaches it through a single-cycle select/write/address port with combinational read data. The bank holds a hold bit that can stall the execution unit before an external memory reference. It also holds a run-status view, a halt interrupt flag with its enable mask that together drive an interrupt output, and a non-maskable interrupt status register fed by three event sources.

Status flags clear when the host reads them, and a write to the abort slot wipes the control state. An event that arrives in the same cycle as a clearing read is kept, so no event is lost. The external NMI pin is active low and asynchronous; it passes through a two-flop synchronizer before falling-edge detection.

Register slots, at word offsets in a wider coprocessor address window: 0 hold control, 1 run status, 2 halt flag, 3 halt mask, 4 NMI status, 5 abort. Any other offset belongs to the coprocessor's working space and reads 0 from this bank.

Top module: `cpu_cop_regs`

## Requirements
- R1: After reset every register slot reads 0, `irq_out` and `nmi_req` are 0, and `xref_go` follows `xref_req`.
- R2: Slot 0 bit 0 is the hold bit and is read/write; bits 15..1 read 0. While hold is 1, `xref_go` stays 0 even when `xref_req` is 1; once hold is back at 0, `xref_go` equals `xref_req`.
- R3: A write to slot 5 clears the hold bit, the halt flag and the halt mask in the following cycle. Slot 5 reads 0.
- R4: Slot 1 bit 0 reads the `exec_running` input. Writes to slot 1 have no effect.
- R5: A one-cycle `exec_stopped` pulse sets the halt flag, which is slot 2 bit 0. Reading slot 2 returns the flag and then clears it. Writes to slot 2 have no effect.
- R6: Slot 3 bit 0 is the read/write halt mask, where 1 means enabled. `irq_out` is 1 exactly when the halt flag and the mask are both 1.
- R7: Slot 4 holds the NMI status: bit 0 is the external-pin event, bit 1 is the undefined-instruction event, bit 2 is the access error, and bits 15..3 read 0. A `undef_attempt` pulse sets bit 1. A high-to-low transition on `nmi_pin_n` sets bit 0 on the third rising clock edge after the pin falls. A low-to-high transition sets nothing.
- R8: A host access, read or write, to any offset other than 0..5 while `exec_running` is 1 sets NMI status bit 2. Accesses to offsets 0..5, and any access while idle, leave bit 2 unchanged.
- R9: `nmi_req` is 1 while any NMI status bit is 1. Reading slot 4 returns the bits and then clears them all. Writes to slot 4 have no effect.
- R10: When a set event and a clearing read of the same flag fall in the same cycle, the read returns the old value and the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access to the coprocessor window this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word offset in the coprocessor window |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data (combinational, value before any clear) |
| exec_running | input | 1 | Execution unit is busy with a command list |
| exec_stopped | input | 1 | One-cycle pulse when command-list execution stops |
| undef_attempt | input | 1 | One-cycle pulse on a breakpoint or reserved instruction attempt |
| xref_req | input | 1 | Execution unit wants an external memory reference |
| xref_go | output | 1 | Permission to perform the reference |
| nmi_pin_n | input | 1 | Asynchronous external NMI pin, active low |
| irq_out | output | 1 | Maskable halt interrupt |
| nmi_req | output | 1 | Non-maskable interrupt request to the host |

## Verification
The bench aims at the same-cycle collision of a status event with the read that clears it. A design that let the clear win would silently drop a halt or an undefined-instruction event, and the follow-up read would show 0. It times the external pin through the synchronizer to the exact edge, so one flop too many or too few shows up as early or late status. It also checks that a rising pin edge sets nothing. It walks every whitelisted slot while running to catch an error bit raised by a legal access, and it checks the working space while idle to catch one raised regardless of run state. Writes to the read-only slots and abort side effects are checked through read-back and through `irq_out` and `xref_go`.

// File: rtl/cpu_cop_regs.sv
module cpu_cop_regs #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          exec_running,
  input  logic          exec_stopped,
  input  logic          undef_attempt,
  input  logic          xref_req,
  output logic          xref_go,
  input  logic          nmi_pin_n,
  output logic          irq_out,
  output logic          nmi_req
);
  localparam logic [AW-1:0] A_HOLD  = AW'(0);
  localparam logic [AW-1:0] A_RUN   = AW'(1);
  localparam logic [AW-1:0] A_HALT  = AW'(2);
  localparam logic [AW-1:0] A_MASK  = AW'(3);
  localparam logic [AW-1:0] A_NMI   = AW'(4);
  localparam logic [AW-1:0] A_ABORT = AW'(5);

  logic       hold, halt, mask;
  logic [2:0] nmist;
  logic       pin_s1, pin_s2, pin_s3;

  wire rd      = host_sel & ~host_wr;
  wire wr      = host_sel &  host_wr;
  wire in_map  = host_addr <= A_ABORT;
  wire abort   = wr && host_addr == A_ABORT;
  wire rd_halt = rd && host_addr == A_HALT;
  wire rd_nmi  = rd && host_addr == A_NMI;
  wire pin_fall = pin_s3 & ~pin_s2;
  wire acc_err  = host_sel & ~in_map & exec_running;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {pin_s1, pin_s2, pin_s3} <= 3'b111;
    else        {pin_s1, pin_s2, pin_s3} <= {nmi_pin_n, pin_s1, pin_s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold  <= 1'b0;
      mask  <= 1'b0;
      halt  <= 1'b0;
      nmist <= 3'b000;
    end else begin
      if (abort) begin
        hold <= 1'b0;
        mask <= 1'b0;
      end else if (wr && host_addr == A_HOLD) begin
        hold <= host_wdata[0];
      end else if (wr && host_addr == A_MASK) begin
        mask <= host_wdata[0];
      end
      halt  <= exec_stopped | (halt & ~rd_halt & ~abort);
      nmist <= {acc_err, undef_attempt, pin_fall} | (rd_nmi ? 3'b000 : nmist);
    end

  always_comb begin
    host_rdata = '0;
    if (rd)
      unique case (host_addr)
        A_HOLD:  host_rdata[0]   = hold;
        A_RUN:   host_rdata[0]   = exec_running;
        A_HALT:  host_rdata[0]   = halt;
        A_MASK:  host_rdata[0]   = mask;
        A_NMI:   host_rdata[2:0] = nmist;
        default: host_rdata      = '0;
      endcase
  end

  assign xref_go = xref_req & ~hold;
  assign irq_out = halt & mask;
  assign nmi_req = |nmist;

  p_hold_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && host_addr == A_HOLD && host_wdata[0]) |=> !xref_go);

  p_abort_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !exec_stopped) |=> (!irq_out && !hold && !mask));

  p_stop_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stopped && mask && !abort && !wr) |=> irq_out);

  p_undef_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    undef_attempt |=> nmi_req);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !in_map && exec_running) |=> nmist[2]);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stopped && rd_halt) |=> halt);
endmodule

// File: tb/tb_cpu_cop_regs.sv
module tb_cpu_cop_regs;
  logic        clk = 0, rst_n = 0;
  logic        host_sel = 0, host_wr = 0;
  logic [7:0]  host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic        exec_running = 0, exec_stopped = 0, undef_attempt = 0, xref_req = 0;
  logic        nmi_pin_n = 1;
  logic        xref_go, irq_out, nmi_req;
  int n_chk = 0, n_bad = 0;
  logic        done = 0;

  always #10 clk = ~clk;

  cpu_cop_regs dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); host_sel = 1; host_wr = 0; host_addr = a;
    #5 d = host_rdata;
    @(negedge clk); host_sel = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 6; a++) begin rd(8'(a), d); chk("R1 slot", d, 0); end
    chk("R1 irq", 16'(irq_out), 0);
    chk("R1 nmi", 16'(nmi_req), 0);
    xref_req = 1; #1 chk("R1 go", 16'(xref_go), 1); xref_req = 0;
  endtask

  task automatic t_hold;
    logic [15:0] d;
    wr(0, 16'hFFFF); rd(0, d); chk("R2 readback", d, 16'h0001);
    xref_req = 1; #1 chk("R2 stall", 16'(xref_go), 0);
    wr(0, 16'h0000); #1 chk("R2 release", 16'(xref_go), 1); xref_req = 0;
  endtask

  task automatic t_run;
    logic [15:0] d;
    exec_running = 1; rd(1, d); chk("R4 run", d, 1);
    exec_running = 0; wr(1, 16'hFFFF); rd(1, d); chk("R4 idle/ro", d, 0);
  endtask

  task automatic stop_pulse;
    @(negedge clk); exec_stopped = 1; @(negedge clk); exec_stopped = 0;
  endtask

  task automatic t_halt;
    logic [15:0] d;
    wr(2, 16'h0001); rd(2, d); chk("R5 ro", d, 0);
    stop_pulse(); chk("R6 masked", 16'(irq_out), 0);
    wr(3, 16'h0001); rd(3, d); chk("R6 mask rw", d, 1);
    chk("R6 irq", 16'(irq_out), 1);
    rd(2, d); chk("R5 flag", d, 1);
    chk("R6 irq cleared", 16'(irq_out), 0);
    rd(2, d); chk("R5 clear on read", d, 0);
  endtask

  task automatic t_abort;
    logic [15:0] d;
    wr(0, 1); stop_pulse(); chk("R3 pre irq", 16'(irq_out), 1);
    wr(5, 16'hFFFF);
    chk("R3 irq", 16'(irq_out), 0);
    rd(0, d); chk("R3 hold", d, 0);
    rd(3, d); chk("R3 mask", d, 0);
    rd(2, d); chk("R3 halt", d, 0);
    rd(5, d); chk("R3 slot5", d, 0);
  endtask

  task automatic t_nmi_src;
    logic [15:0] d;
    @(negedge clk); undef_attempt = 1; @(negedge clk); undef_attempt = 0;
    chk("R9 req", 16'(nmi_req), 1);
    wr(4, 16'h0000); rd(4, d); chk("R7 und bit1 / R9 ro", d, 16'h0002);
    chk("R9 cleared", 16'(nmi_req), 0);
    @(negedge clk); nmi_pin_n = 0;
    @(negedge clk); @(negedge clk); chk("R7 pin not early", 16'(nmi_req), 0);
    @(negedge clk); chk("R7 pin edge3", 16'(nmi_req), 1);
    rd(4, d); chk("R7 ext bit0", d, 16'h0001);
    nmi_pin_n = 1; repeat (4) @(negedge clk);
    chk("R7 rise ignored", 16'(nmi_req), 0);
  endtask

  task automatic t_err;
    logic [15:0] d;
    exec_running = 1;
    for (int a = 0; a < 6; a++) if (a != 4 && a != 5) rd(8'(a), d);
    wr(0, 0); wr(3, 0); wr(5, 0);
    chk("R8 whitelist", 16'(nmi_req), 0);
    rd(8'h40, d); chk("R8 window reads 0", d, 0);
    rd(4, d); chk("R8 err bit2", d, 16'h0004);
    wr(8'h06, 16'h1234); rd(4, d); chk("R8 err on write", d, 16'h0004);
    exec_running = 0; wr(8'h80, 0); rd(8'h80, d);
    chk("R8 idle no err", 16'(nmi_req), 0);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    @(negedge clk); exec_stopped = 1; host_sel = 1; host_wr = 0; host_addr = 2;
    #5 chk("R10 halt old", host_rdata, 0);
    @(negedge clk); exec_stopped = 0; host_sel = 0;
    rd(2, d); chk("R10 halt kept", d, 1);
    @(negedge clk); undef_attempt = 1; host_sel = 1; host_wr = 0; host_addr = 4;
    #5 chk("R10 nmi old", host_rdata, 0);
    @(negedge clk); undef_attempt = 0; host_sel = 0;
    rd(4, d); chk("R10 und kept", d, 16'h0002);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset(); t_hold(); t_run(); t_halt(); t_abort();
    t_nmi_src(); t_err(); t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule